// File: doc/BRIEF.md
# Boot Geometry Flag Decoder

This block watches the bytes of the first 160 bytes fetched from page 0 of a boot flash. It recovers the device geometry from redundant marker fields embedded in that page. Each field is a 32-byte window. The writer fills a window with copies of 0x55 or 0xAA, so a handful of corrupted bytes cannot change the answer. The block tallies both marker values in each window and takes a thresholded vote. It then reports the data bus width, the number of row address cycles and a page-size code.

The block issues no flash reads itself. An external controller pulses `start`, streams the page bytes through `byte_valid`/`byte_data`, and reacts to the outcome:

- **`done`**: the results are ready.
- **`retry`**: the bus-width field was unreadable. The controller should read the page again using the other column-address cycle count, which the block shows on `col_cyc3`.
- **`done` with `fatal`**: that second attempt also failed.

Top module: `boot_flag_detector`

## Requirements
- R1: After reset, done, retry, col_cyc3, bus16, row3, page_code, err and fatal are all 0.
- R2: A field window decodes as 0x55 when at least 7 of its 32 bytes equal 0x55, and otherwise as 0xAA when at least 7 equal 0xAA. A window with only 6 of each decodes as invalid.
- R3: When both counts in a window reach 7, the window decodes as 0x55.
- R4: The window at byte offsets 0..31 sets bus16. A 0x55 vote gives bus16=0 (8-bit bus) and a 0xAA vote gives bus16=1 (16-bit bus).
- R5: The window at offsets 64..95 sets row3. A 0x55 vote gives row3=0 (2 cycles) and a 0xAA vote gives row3=1 (3 cycles). An invalid vote gives err=1 and row3=0.
- R6: The windows at offsets 96..127 (high) and 128..159 (low) form page_code = {high is 0xAA, low is 0xAA}. The codes are 0 for 512 bytes, 1 for 2048, 2 for 4096 and 3 for 8192. If either window is invalid, err=1 and page_code=0.
- R7: The block ignores bytes at offsets 32..63, and bytes presented while no scan is in progress.
- R8: done pulses for exactly one cycle, in the second cycle after the cycle in which byte 159 is accepted. The results hold until the next start, and start clears them to 0.
- R9: If the bus-width window is invalid on a first attempt, the block pulses retry instead of done. The next start then sets col_cyc3=1.
- R10: If the bus-width window is invalid on an attempt with col_cyc3=1, the block pulses done with fatal=1 and bus16, row3, page_code and err at 0.
- R11: A start that does not follow a retry pulse sets col_cyc3=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new scan at byte 0 |
| byte_valid | input | 1 | byte_data carries the next page byte |
| byte_data | input | 8 | Page byte |
| col_cyc3 | output | 1 | Column cycle count for this attempt: 0 = 2 cycles, 1 = 3 cycles |
| retry | output | 1 | One-cycle request to rescan with col_cyc3 = 1 |
| done | output | 1 | One-cycle pulse: results valid |
| bus16 | output | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| row3 | output | 1 | 1 = 3 row cycles, 0 = 2 row cycles |
| page_code | output | 2 | 0 = 512, 1 = 2048, 2 = 4096, 3 = 8192 bytes |
| err | output | 1 | Row or page field undecodable |
| fatal | output | 1 | Bus-width field undecodable on both attempts |

## Verification
Two kinds of internal fault show up at the ports:

- **A stray tally or a wrongly placed window boundary.** This shows up as a wrong geometry bit or code at the single done pulse that ends the same scan. The bench therefore uses threshold counts of exactly 6 and 7, and filler bytes in the ignored gap, so that an off-by-one count or position changes a visible field.
- **A lost attempt flag.** This shows up on the very next start, through col_cyc3, and at the end of that scan as a retry where a fatal done was due, or the reverse.

// File: rtl/boot_flag_pkg.sv
package boot_flag_pkg;

  typedef enum logic [1:0] {
    VOTE_INV = 2'd0,
    VOTE_55  = 2'd1,
    VOTE_AA  = 2'd2
  } vote_e;

  // Thresholded vote; the 0x55 marker wins when both counts qualify.
  function automatic vote_e decide(input int unsigned c55, input int unsigned caa,
                                   input int unsigned thr);
    if (c55 >= thr)      return VOTE_55;
    else if (caa >= thr) return VOTE_AA;
    else                 return VOTE_INV;
  endfunction

  function automatic logic page_ok(input vote_e hi, input vote_e lo);
    return (hi != VOTE_INV) && (lo != VOTE_INV);
  endfunction

  function automatic logic [1:0] page_code_of(input vote_e hi, input vote_e lo);
    if (!page_ok(hi, lo)) return 2'd0;
    return {hi == VOTE_AA, lo == VOTE_AA};
  endfunction

endpackage

// File: rtl/bfd_position.sv
module bfd_position #(
  parameter int TOTAL = 160,
  parameter int WIN   = 32,
  localparam int PW   = $clog2(TOTAL),
  localparam int NWIN = TOTAL / WIN,
  localparam int IW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          byte_valid,
  output logic          accept,
  output logic [IW-1:0] win_idx,
  output logic          win_first,
  output logic          win_last,
  output logic          scan_last
);
  localparam logic [PW-1:0] LAST_POS = PW'(TOTAL - 1);

  logic          busy_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] win_off;

  assign accept    = busy_q && byte_valid && !start;
  assign win_idx   = IW'(pos_q / PW'(WIN));
  assign win_off   = pos_q % PW'(WIN);
  assign win_first = (win_off == '0);
  assign win_last  = (win_off == PW'(WIN - 1));
  assign scan_last = (pos_q == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      pos_q  <= '0;
    end else if (accept) begin
      if (scan_last) busy_q <= 1'b0;
      else           pos_q  <= pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/bfd_tally.sv
module bfd_tally
  import boot_flag_pkg::*;
#(
  parameter int WIN    = 32,
  parameter int THRESH = 7,
  localparam int CW    = $clog2(WIN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       win_first,
  input  logic [7:0] byte_data,
  output vote_e      vote_now
);
  logic [CW-1:0] c55_q, caa_q, c55_n, caa_n;

  assign c55_n    = (win_first ? '0 : c55_q) + CW'(byte_data == 8'h55);
  assign caa_n    = (win_first ? '0 : caa_q) + CW'(byte_data == 8'hAA);
  assign vote_now = decide(32'(c55_n), 32'(caa_n), 32'(THRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c55_q <= '0;
      caa_q <= '0;
    end else if (accept) begin
      c55_q <= c55_n;
      caa_q <= caa_n;
    end
  end
endmodule

// File: rtl/boot_flag_detector.sv
module boot_flag_detector
  import boot_flag_pkg::*;
#(
  parameter int TOTAL    = 160,
  parameter int WIN      = 32,
  parameter int THRESH   = 7,
  parameter int BUS_WIN  = 0,
  parameter int ROW_WIN  = 2,
  parameter int PGHI_WIN = 3,
  parameter int PGLO_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       col_cyc3,
  output logic       retry,
  output logic       done,
  output logic       bus16,
  output logic       row3,
  output logic [1:0] page_code,
  output logic       err,
  output logic       fatal
);
  localparam int NF   = 4;
  localparam int NWIN = TOTAL / WIN;
  localparam int IW   = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int FIELD_WIN [NF] = '{BUS_WIN, ROW_WIN, PGHI_WIN, PGLO_WIN};

  logic          accept, win_first, win_last, scan_last;
  logic [IW-1:0] win_idx;
  vote_e         vote_now;
  vote_e         field_q [NF];
  logic          scan_end_q;   // finalize event, one cycle after byte TOTAL-1
  logic          attempt_q;    // 1 = second attempt (3 column cycles)
  logic          retry_pend_q;
  logic          bus_bad;

  bfd_position #(.TOTAL(TOTAL), .WIN(WIN)) u_pos (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
    .accept(accept), .win_idx(win_idx), .win_first(win_first),
    .win_last(win_last), .scan_last(scan_last)
  );

  bfd_tally #(.WIN(WIN), .THRESH(THRESH)) u_tally (
    .clk(clk), .rst_n(rst_n), .accept(accept), .win_first(win_first),
    .byte_data(byte_data), .vote_now(vote_now)
  );

  for (genvar f = 0; f < NF; f++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        field_q[f] <= VOTE_INV;
      else if (start)
        field_q[f] <= VOTE_INV;
      else if (accept && win_last && (win_idx == IW'(FIELD_WIN[f])))
        field_q[f] <= vote_now;
    end
  end

  assign bus_bad  = (field_q[0] == VOTE_INV);
  assign col_cyc3 = attempt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_end_q   <= 1'b0;
      attempt_q    <= 1'b0;
      retry_pend_q <= 1'b0;
      retry        <= 1'b0;
      done         <= 1'b0;
      bus16        <= 1'b0;
      row3         <= 1'b0;
      page_code    <= 2'd0;
      err          <= 1'b0;
      fatal        <= 1'b0;
    end else begin
      scan_end_q <= accept && scan_last;
      retry      <= 1'b0;
      done       <= 1'b0;
      if (start) begin
        scan_end_q   <= 1'b0;
        attempt_q    <= retry_pend_q;
        retry_pend_q <= 1'b0;
        bus16        <= 1'b0;
        row3         <= 1'b0;
        page_code    <= 2'd0;
        err          <= 1'b0;
        fatal        <= 1'b0;
      end else if (scan_end_q) begin
        if (bus_bad && !attempt_q) begin
          retry        <= 1'b1;
          retry_pend_q <= 1'b1;
        end else if (bus_bad) begin
          done  <= 1'b1;
          fatal <= 1'b1;
        end else begin
          done      <= 1'b1;
          bus16     <= (field_q[0] == VOTE_AA);
          row3      <= (field_q[1] == VOTE_AA);
          page_code <= page_code_of(field_q[2], field_q[3]);
          err       <= (field_q[1] == VOTE_INV) || !page_ok(field_q[2], field_q[3]);
        end
      end
    end
  end
endmodule

// File: rtl/boot_flag_detector_chk.sv
module boot_flag_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       scan_end,
  input logic       col_cyc3,
  input logic       retry,
  input logic       done,
  input logic       bus16,
  input logic       row3,
  input logic [1:0] page_code,
  input logic       err,
  input logic       fatal
);
  assert_done_after_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(scan_end));

  assert_hold_results_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !scan_end) |=> $stable({bus16, row3, page_code, err, fatal}));

  assert_no_retry_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && retry));

  assert_retry_first_attempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !col_cyc3);

  assert_fatal_second_attempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> col_cyc3);

  assert_fatal_clears_geometry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> (!bus16 && !row3 && page_code == 2'd0 && !err));
endmodule

bind boot_flag_detector boot_flag_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .scan_end(scan_end_q),
  .col_cyc3(col_cyc3), .retry(retry), .done(done), .bus16(bus16), .row3(row3),
  .page_code(page_code), .err(err), .fatal(fatal)
);

// File: tb/boot_flag_detector_tb.sv
module boot_flag_detector_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic col_cyc3, retry, done, bus16, row3, err, fatal;
  logic [1:0] page_code;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  boot_flag_detector u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .col_cyc3(col_cyc3), .retry(retry), .done(done),
    .bus16(bus16), .row3(row3), .page_code(page_code), .err(err), .fatal(fatal)
  );

  // {gap byte, (n55,naa) x windows 0,64,96,128, exp bus16,row3,page_code,err}
  localparam int NV = 6;
  localparam logic [60:0] VEC [NV] = '{
    {8'h00, 6'd32,6'd0,  6'd32,6'd0,  6'd32,6'd0,  6'd32,6'd0,  1'b0,1'b0,2'd0,1'b0},
    {8'hAA, 6'd0,6'd32,  6'd0,6'd32,  6'd0,6'd32,  6'd0,6'd32,  1'b1,1'b1,2'd3,1'b0},
    {8'h55, 6'd7,6'd0,   6'd0,6'd7,   6'd7,6'd0,   6'd0,6'd7,   1'b0,1'b1,2'd1,1'b0},
    {8'hAA, 6'd8,6'd8,   6'd7,6'd20,  6'd0,6'd8,   6'd9,6'd9,   1'b0,1'b0,2'd2,1'b0},
    {8'h55, 6'd32,6'd0,  6'd6,6'd6,   6'd32,6'd0,  6'd32,6'd0,  1'b0,1'b0,2'd0,1'b1},
    {8'h00, 6'd0,6'd32,  6'd32,6'd0,  6'd6,6'd26,  6'd6,6'd6,   1'b1,1'b0,2'd0,1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [60:0] v, input int i);
    int w = i / 32, off = i % 32, f, base, n55, naa;
    if (w == 1) return v[60:53];
    f = (w == 0) ? 0 : w - 1;
    base = 5 + (3 - f) * 12;
    naa = int'(v[base +: 6]);
    n55 = int'(v[base + 6 +: 6]);
    if (off < n55) return 8'h55;
    if (off < n55 + naa) return 8'hAA;
    return 8'h00;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Feeds 160 bytes; leaves time at the negedge right after the last accept.
  task automatic feed(input logic [60:0] v);
    for (int i = 0; i < 160; i++) begin
      byte_valid = 1'b1; byte_data = byte_at(v, i);
      @(negedge clk);
    end
    byte_valid = 1'b0; byte_data = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);   check("R1 retry", retry, 0);
    check("R1 col_cyc3", col_cyc3, 0);
    check("R1 geometry", {bus16, row3, page_code, err, fatal}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      pulse_start();
      check("R11 col_cyc3 fresh start", col_cyc3, 0);
      feed(VEC[k]);
      check("R8 done not yet", done, 0);
      @(negedge clk);
      check("R8 done pulse", done, 1);
      check("R4 bus16", bus16, VEC[k][4]);
      check("R5 row3", row3, VEC[k][3]);
      check("R6 page_code", page_code, VEC[k][2:1]);
      check("R5/R6 err", err, VEC[k][0]);
      check("R10 fatal", fatal, 0);
      @(negedge clk);
      check("R8 done single cycle", done, 0);
    end

    // R7/R8: idle bytes ignored, results held, start clears
    for (int i = 0; i < 40; i++) begin
      byte_valid = 1'b1; byte_data = 8'h55; @(negedge clk);
    end
    byte_valid = 1'b0;
    check("R7 idle bytes no done", done, 0);
    check("R8 hold", {bus16, row3, page_code, err}, {1'b1, 1'b0, 2'd0, 1'b1});
    pulse_start();
    check("R8 start clears", {bus16, row3, page_code, err, fatal}, 0);

    // R9: bus field invalid on first attempt -> retry
    feed({8'h55, 6'd6,6'd6, 6'd32,6'd0, 6'd32,6'd0, 6'd32,6'd0, 5'd0});
    @(negedge clk);
    check("R9 retry pulse", retry, 1);
    check("R9 no done", done, 0);
    pulse_start();
    check("R9 col_cyc3 after retry", col_cyc3, 1);
    feed(VEC[1]);
    @(negedge clk);
    check("R9 second attempt done", done, 1);
    check("R9 second attempt bus16", bus16, 1);
    check("R10 not fatal", fatal, 0);

    // R11: new start without retry returns to 2 cycles
    pulse_start();
    check("R11 col_cyc3 reset", col_cyc3, 0);
    feed({8'h00, 6'd0,6'd0, 6'd32,6'd0, 6'd32,6'd0, 6'd32,6'd0, 5'd0});
    @(negedge clk);
    check("R9 retry again", retry, 1);
    pulse_start();
    check("R9 col_cyc3 set", col_cyc3, 1);
    // R10: second attempt also invalid
    feed({8'hAA, 6'd0,6'd5, 6'd0,6'd32, 6'd0,6'd32, 6'd0,6'd32, 5'd0});
    @(negedge clk);
    check("R10 fatal done", done, 1);
    check("R10 fatal retry", retry, 0);
    check("R10 fatal flag", fatal, 1);
    check("R10 geometry zero", {bus16, row3, page_code, err}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule